// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. It frees the bus after a protocol interruption or a system reset that left a slave part way through a byte, still holding the data line low. On a request it toggles the clock line at a rate set by a parameter and watches the data line while the clock is released. When the data line is seen high, it stops toggling. It then places a start condition on the bus so that every slave resynchronizes, follows it with a stop condition so the bus is left idle, and pulses `done`. If the data line is still low after the last allowed clock, it releases both lines and pulses `fail`.

Both lines are open drain. The block drives each one only through an enable, where 1 pulls the wire low. The enclosing logic must present the resolved data-line level on `sdaIn`, synchronous to `clk`. A request that arrives while a sequence is running has no effect.

Top module: `busRecover`

## Requirements
- R1: After reset both drive enables are 0 (lines released) and `busy`, `done` and `fail` are 0.
- R2: When `req` is 1 while idle, the clock enable is 1 (clock low) for exactly PHASE_CLKS cycles and then 0 (clock released) for exactly PHASE_CLKS cycles. This pair repeats, and the data enable stays 0 throughout the pulsing.
- R3: The data line is sampled on the last cycle of each released-clock phase. A high sample ends the pulsing at once.
- R4: At most MAX_PULSES (default 9) clock-low phases are issued. If the sample after the last one is still low, `fail` is 1 for one cycle, both enables are 0 and the block is idle.
- R5: After a high sample, the data enable goes to 1 while the clock stays released (a start condition) for PHASE_CLKS cycles. The clock is then pulled low for PHASE_CLKS cycles.
- R6: The block then releases the clock with data still low for PHASE_CLKS cycles, then releases data with the clock high (a stop condition) for PHASE_CLKS cycles, then pulses `done` for one cycle. `done` and `fail` are never 1 together.
- R7: `req` while `busy` is 1 is ignored: the sequence in progress is unchanged and no second sequence follows.
- R8: The two drive enables never change in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a recovery sequence (sampled while idle) |
| sdaIn | input | 1 | Resolved data-line level, synchronous to clk |
| sclDriveLow | output | 1 | 1 pulls the clock line low |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: bus freed and start/stop issued |
| fail | output | 1 | One-cycle pulse: data still low after the last pulse |

## Verification
The bench models a slave that lets go of the data line after a chosen number of released-clock phases: zero, three, exactly nine, and never. The nine-phase case catches an off-by-one limit, which would give up one clock early, and the never case catches a sequencer that keeps clocking past the limit or leaves a line driven after failing. A request injected mid-sequence would restart the counter or trigger a second sequence in a design that does not ignore it. Phase lengths are measured at the pins, so a timer that wraps one count late shows up as a stretched phase.

// File: rtl/busRecoverPkg.sv
package busRecoverPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STA,
    ST_STA_LOW,
    ST_STO_HIGH,
    ST_STO
  } recState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic cntLoad;
    logic cntStep;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic phaseEnd;
    logic cntAtMax;
  } dpStat_t;

endpackage

// File: rtl/busRecoverDp.sv
module busRecoverDp
  import busRecoverPkg::*;
#(
  parameter int PHASE_CLKS = 4,
  parameter int MAX_PULSES = 9
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtl_t  ctl,
  output dpStat_t stat
);

  localparam int TW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] PHASE_LAST = TW'(PHASE_CLKS - 1);
  localparam logic [CW-1:0] CNT_MAX    = CW'(MAX_PULSES);

  logic [TW-1:0] phaseTimer;
  logic [CW-1:0] pulseCnt;
  logic          phaseEnd;

  assign phaseEnd      = (phaseTimer == PHASE_LAST);
  assign stat.phaseEnd = phaseEnd;
  assign stat.cntAtMax = (pulseCnt == CNT_MAX);

  // phase timer: every phase lasts PHASE_CLKS cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       phaseTimer <= '0;
    else if (ctl.timerClr || phaseEnd) phaseTimer <= '0;
    else                             phaseTimer <= phaseTimer + 1'b1;
  end

  // clock pulse counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pulseCnt <= '0;
    else if (ctl.cntLoad) pulseCnt <= CW'(1);
    else if (ctl.cntStep) pulseCnt <= pulseCnt + 1'b1;
  end

  a_r2_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    phaseTimer <= PHASE_LAST);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_MAX);

endmodule

// File: rtl/busRecoverCtrl.sv
module busRecoverCtrl
  import busRecoverPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    sdaIn,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    sclDriveLow,
  output logic    sdaDriveLow,
  output logic    busy,
  output logic    done,
  output logic    fail
);

  recState_t state, stateNxt;
  logic      doneNxt, failNxt;
  logic      sampleHigh, sampleLow;

  assign sampleHigh = (state == ST_HIGH) && stat.phaseEnd && sdaIn;
  assign sampleLow  = (state == ST_HIGH) && stat.phaseEnd && !sdaIn;

  always_comb begin
    stateNxt = state;
    doneNxt  = 1'b0;
    failNxt  = 1'b0;
    case (state)
      ST_IDLE:     if (req) stateNxt = ST_LOW;
      ST_LOW:      if (stat.phaseEnd) stateNxt = ST_HIGH;
      ST_HIGH: begin
        if (sampleHigh) stateNxt = ST_STA;
        else if (sampleLow && stat.cntAtMax) begin
          stateNxt = ST_IDLE;
          failNxt  = 1'b1;
        end else if (sampleLow) stateNxt = ST_LOW;
      end
      ST_STA:      if (stat.phaseEnd) stateNxt = ST_STA_LOW;
      ST_STA_LOW:  if (stat.phaseEnd) stateNxt = ST_STO_HIGH;
      ST_STO_HIGH: if (stat.phaseEnd) stateNxt = ST_STO;
      ST_STO: if (stat.phaseEnd) begin
        stateNxt = ST_IDLE;
        doneNxt  = 1'b1;
      end
      default:     stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
      fail  <= failNxt;
    end
  end

  always_comb begin
    ctl.timerClr = (state == ST_IDLE);
    ctl.cntLoad  = (state == ST_IDLE) && req;
    ctl.cntStep  = sampleLow && !stat.cntAtMax;
  end

  assign sclDriveLow = (state == ST_LOW) || (state == ST_STA_LOW);
  assign sdaDriveLow = (state == ST_STA) || (state == ST_STA_LOW) ||
                       (state == ST_STO_HIGH);
  assign busy        = (state != ST_IDLE);

  a_r3_stop_on_high: assert property (@(posedge clk) disable iff (!rstN)
    sampleHigh |=> (sdaDriveLow && !sclDriveLow));

  a_r6_done_fail_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !sdaDriveLow && !sclDriveLow));

endmodule

// File: rtl/busRecover.sv
module busRecover
  import busRecoverPkg::*;
#(
  parameter int PHASE_CLKS = 4,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  input  logic sdaIn,
  output logic sclDriveLow,
  output logic sdaDriveLow,
  output logic busy,
  output logic done,
  output logic fail
);

  dpCtl_t  ctl;
  dpStat_t stat;

  busRecoverCtrl uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .sdaIn(sdaIn), .stat(stat), .ctl(ctl),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done), .fail(fail)
  );

  busRecoverDp #(.PHASE_CLKS(PHASE_CLKS), .MAX_PULSES(MAX_PULSES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat)
  );

  a_r8_no_joint_edge: assert property (@(posedge clk) disable iff (!rstN)
    !($changed(sclDriveLow) && $changed(sdaDriveLow)));

  a_r5_start_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclDriveLow);

  a_r4_fail_release: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (!sclDriveLow && !sdaDriveLow && !busy));

  a_r2_no_sda_while_pulsing: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $rose(sclDriveLow) && $past(busy)) |-> (sdaDriveLow == $past(sdaDriveLow)));

endmodule

// File: tb/sim_busRecover.sv
`timescale 1ns/1ps
module sim_busRecover;
  localparam int PH   = 4;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0;
  logic sdaIn;
  logic sclDriveLow, sdaDriveLow, busy, done, fail;

  always #2 clk = ~clk;

  busRecover #(.PHASE_CLKS(PH), .MAX_PULSES(MAXP)) u0 (
    .clk(clk), .rstN(rstN), .req(req), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done), .fail(fail)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // slave model: holds data low until it has seen releaseAfter clock highs
  int  releaseAfter = 0;
  int  highSeen = 0;
  logic slaveHold;
  assign slaveHold = (highSeen < releaseAfter);
  assign sdaIn = !(sdaDriveLow || slaveHold);

  // reference model
  int mState = 0, mTick = 0, mCnt = 0;
  bit mDone = 0, mFail = 0;

  always @(posedge clk) begin
    mDone = 0;
    mFail = 0;
    if (!rstN) begin
      mState = 0; mTick = 0; mCnt = 0;
    end else if (mState == 0) begin
      if (req) begin mState = 1; mTick = 0; mCnt = 1; end
    end else if (mTick == PH - 1) begin
      mTick = 0;
      case (mState)
        1: mState = 2;
        2: begin
          if (sdaIn) mState = 3;
          else if (mCnt == MAXP) begin mState = 0; mFail = 1; end
          else begin mState = 1; mCnt++; end
        end
        3: mState = 4;
        4: mState = 5;
        5: mState = 6;
        6: begin mState = 0; mDone = 1; end
        default: mState = 0;
      endcase
    end else mTick++;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // pin monitor and per-cycle comparison
  bit prevScl = 0;
  int lowRun = 0, lastLowLen = 0, pulses = 0;
  bit sawDone = 0, sawFail = 0;

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R2 sclDriveLow", sclDriveLow, (mState == 1 || mState == 4));
      check("R5 sdaDriveLow", sdaDriveLow, (mState == 3 || mState == 4 || mState == 5));
      check("R7 busy", busy, (mState != 0));
      check("R6 done", done, mDone);
      check("R4 fail", fail, mFail);
    end
    if (sclDriveLow) lowRun++;
    if (prevScl && !sclDriveLow) begin
      highSeen++;
      lastLowLen = lowRun;
      lowRun = 0;
    end
    if (!prevScl && sclDriveLow && !sdaDriveLow) pulses++;
    if (done) sawDone = 1;
    if (fail) sawFail = 1;
    prevScl = sclDriveLow;
  end

  task automatic runCase(input int rel, input int expPulses, input bit expFail,
                         input bit poke);
    releaseAfter = rel;
    highSeen = 0; pulses = 0; sawDone = 0; sawFail = 0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    for (int i = 0; i < 3000 && !sawDone && !sawFail; i++) begin
      @(negedge clk);
      if (poke && i == 6) req = 1'b1;
      if (poke && i == 7) req = 1'b0;
    end
    check("R4 pulse count", pulses, expPulses);
    check("R3 done seen", sawDone, !expFail);
    check("R4 fail seen", sawFail, expFail);
    check("R2 low phase length", lastLowLen, PH);
    for (int i = 0; i < 12; i++) @(negedge clk);
    check("R7 idle after sequence", busy, 0);
    check("R1 lines released", sclDriveLow | sdaDriveLow, 0);
    releaseAfter = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset scl", sclDriveLow, 0);
    check("R1 reset sda", sdaDriveLow, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset flags", done | fail, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runCase(0, 1, 0, 0);      // R3 free bus: one pulse
    runCase(3, 3, 0, 1);      // R7 request mid-sequence ignored
    runCase(MAXP, MAXP, 0, 0);// R4 release on the last allowed pulse
    runCase(100, MAXP, 1, 0); // R4 never released: fail
    runCase(0, 1, 0, 0);      // R6 recovery after fail
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule